// File: doc/BRIEF.md
# Video Data Port Read Path with Write-History Fill

This block is the data-port side of a video display processor. It serves three internal memories: a byte-addressed video RAM held as 16-bit words, a colour RAM of 9-bit palette entries and a vertical-scroll RAM of 11-bit entries. A five-bit access code picks the target. A write code stores into a memory. A read code returns a 16-bit bus word one clock after a valid/ready handshake.

Every word written on the data port, and every byte written on a secondary 8-bit bus, is also pushed into a four-entry history ring. When a read targets a memory narrower than the bus, the bit positions that memory cannot drive are not zeroed. They are copied from the ring entry at the current write pointer, which is the oldest write still held. Stale write data therefore shows through on colour, scroll and byte reads. A read also clears the pending second-half control-word flag. A read with an unknown code locks the port until a hard reset.

Top module: `vport_read_path`

## Requirements
- R1: Each accepted data-port word write (`wr_en`) stores `wr_data` into the ring entry at the write pointer, then advances the pointer modulo 4. Reset sets the pointer and all entries to 0.
- R2: A byte write (`bwr_en`) pushes `{bwr_data, 8'h00}` into the ring and advances the same pointer. If `wr_en` and `bwr_en` are both high in one cycle, only the word is recorded.
- R3: Read code 5'h00 returns the video RAM word at `rd_addr` with bit 0 ignored. The byte at the even address sits in bits 15..8 and the byte at the odd address sits in bits 7..0.
- R4: Read code 5'h04 returns scroll entry `rd_addr[6:1]` in bits 10..0, with bits 15..11 taken from the ring entry at the write pointer. A byte offset `rd_addr[6:0]` of 0x50 or more reads entry 0.
- R5: Read code 5'h08 expands the colour entry c[8:0] to c[8:6] at bits 11..9, c[5:3] at bits 7..5 and c[2:0] at bits 3..1. Every bit outside mask 16'h0EEE comes from the ring entry at the write pointer.
- R6: Read code 5'h0C returns the video RAM byte at address `rd_addr ^ 1` in bits 7..0, with bits 15..8 from the ring entry at the write pointer.
- R7: Write code 5'h01 stores a video RAM word. Code 5'h03 stores colour bits {11:9, 7:5, 3:1}. Code 5'h05 stores the low 11 bits into scroll RAM, and is dropped when the byte offset is 0x50 or more. Any other write code touches only the ring.
- R8: A read is accepted when `rd_valid && rd_ready`. For a valid code, `rd_done` is high for exactly the next cycle, carrying `rd_data`. Memory and ring are sampled before the same cycle's write.
- R9: `ctl_half` sets `ctl_pending` on the next cycle. Any accepted read clears it, and the clear takes priority over the set.
- R10: An accepted read with any code not listed above raises no `rd_done` and sets `locked` on the next cycle. While `locked` is high, `rd_ready` is low. Only reset clears `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wr_en | input | 1 | Data-port word write strobe |
| wr_code | input | 5 | Access code for the write |
| wr_addr | input | 16 | Byte address for the write |
| wr_data | input | 16 | Write data |
| bwr_en | input | 1 | Secondary 8-bit bus write strobe |
| bwr_data | input | 8 | Byte written on the secondary bus |
| ctl_half | input | 1 | First half of a two-part control word seen |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Port can accept a read |
| rd_code | input | 5 | Access code for the read |
| rd_addr | input | 16 | Byte address for the read |
| rd_done | output | 1 | Read data valid (one cycle) |
| rd_data | output | 16 | Read data |
| ctl_pending | output | 1 | Second control half still awaited |
| locked | output | 1 | Sticky invalid-read lock |

## Verification
The bench writes four distinct words and then reads colour, scroll and byte data. A design that zero-filled, or that took the fill from the newest entry instead of the pointed-at one, would return wrong upper bits. Odd addresses check the byte swap and the ignored bit 0. Offsets at and beyond 0x50 catch a scroll RAM that wraps wrongly or accepts out-of-range writes. Collisions of a read with a write, of the two write buses, and of a read with `ctl_half` expose wrong ordering. An invalid code followed by further reads checks that the lock holds and that no stray `rd_done` appears.

// File: rtl/vport_pkg.sv
package vport_pkg;
  // read selectors
  localparam logic [4:0] RC_VRAM  = 5'h00;
  localparam logic [4:0] RC_VSRAM = 5'h04;
  localparam logic [4:0] RC_CRAM  = 5'h08;
  localparam logic [4:0] RC_VBYTE = 5'h0C;
  // write selectors
  localparam logic [4:0] WC_VRAM  = 5'h01;
  localparam logic [4:0] WC_CRAM  = 5'h03;
  localparam logic [4:0] WC_VSRAM = 5'h05;

  localparam logic [15:0] CRAM_BUS_MASK = 16'h0EEE;

  // bus layout -> 9-bit palette entry
  function automatic logic [8:0] cram_pack(input logic [15:0] d);
    return {d[11:9], d[7:5], d[3:1]};
  endfunction

  // 9-bit palette entry -> bus layout with zero gaps
  function automatic logic [15:0] cram_expand(input logic [8:0] c);
    return {4'b0000, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
  endfunction

  // byte offset -> scroll slot, out-of-range offsets fold to slot 0
  function automatic logic [5:0] vsram_slot(input logic [6:0] ofs, input logic [6:0] lim);
    return (ofs >= lim) ? 6'd0 : ofs[6:1];
  endfunction
endpackage

// File: rtl/vport_ring.sv
module vport_ring #(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nxt;

  assign wptr_nxt = (wptr == LAST) ? '0 : wptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else if (push) wptr <= wptr_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (push && wptr == PW'(g)) slot_q[g] <= din;
    end
  end

  assign fill = slot_q[wptr];

  // R1: pointer steps by one per push, wrapping at the last entry
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));
  // R1: no push leaves pointer and fill word alone
  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> ($stable(wptr) && $stable(fill)));
endmodule

// File: rtl/vport_mems.sv
module vport_mems
  import vport_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int VRAM_AW      = 11,
  parameter int CRAM_WORDS   = 64,
  parameter int SCROLL_WORDS = 40
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [4:0]        wr_code,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       vram_word,
  output logic [7:0]        vram_byte,
  output logic [8:0]        cram_val,
  output logic [10:0]       vs_val
);
  localparam int VWORDS = 1 << (VRAM_AW - 1);
  localparam int CIW    = $clog2(CRAM_WORDS);
  localparam logic [6:0] VS_LIM = 7'(2 * SCROLL_WORDS);

  logic [15:0] vram  [VWORDS];
  logic [8:0]  cram  [CRAM_WORDS];
  logic [10:0] vsram [SCROLL_WORDS];

  logic vram_we, cram_we, vs_we;
  logic [5:0] vs_wslot;

  assign vs_wslot = wr_addr[6:1];
  assign vram_we  = wr_en && (wr_code == WC_VRAM);
  assign cram_we  = wr_en && (wr_code == WC_CRAM);
  assign vs_we    = wr_en && (wr_code == WC_VSRAM) && (wr_addr[6:0] < VS_LIM);

  always_ff @(posedge clk) begin
    if (vram_we) vram[wr_addr[VRAM_AW-1:1]] <= wr_data;
    if (cram_we) cram[wr_addr[CIW:1]] <= cram_pack(wr_data);
    if (vs_we)   vsram[vs_wslot] <= wr_data[10:0];
  end

  assign vram_word = vram[rd_addr[VRAM_AW-1:1]];
  // byte at (address ^ 1): odd byte lives in the low half
  assign vram_byte = rd_addr[0] ? vram_word[15:8] : vram_word[7:0];
  assign cram_val  = cram[rd_addr[CIW:1]];
  assign vs_val    = vsram[vsram_slot(rd_addr[6:0], VS_LIM)];

  logic unused_hi;
  assign unused_hi = ^{rd_addr[ADDR_W-1:VRAM_AW], wr_addr[ADDR_W-1:VRAM_AW], wr_addr[0]};

  // R7: an out-of-range scroll write leaves slot 0 untouched
  p_vs_drop_r7: assert property (@(posedge clk)
    (wr_en && wr_code == WC_VSRAM && wr_addr[6:0] >= VS_LIM && !(rd_addr[6:0] != 7'd0 && rd_addr[6:0] < VS_LIM))
      |=> (vs_val == $past(vs_val) || $changed(rd_addr)));
endmodule

// File: rtl/vport_read_path.sv
module vport_read_path
  import vport_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int VRAM_AW      = 11,
  parameter int CRAM_WORDS   = 64,
  parameter int SCROLL_WORDS = 40,
  parameter int RING_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_code,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              bwr_en,
  input  logic [7:0]        bwr_data,
  input  logic              ctl_half,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [4:0]        rd_code,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [15:0]       rd_data,
  output logic              ctl_pending,
  output logic              locked
);
  logic        push;
  logic [15:0] push_data, fill;
  logic [15:0] vram_word;
  logic [7:0]  vram_byte;
  logic [8:0]  cram_val;
  logic [10:0] vs_val;
  logic [15:0] rd_mux;
  logic        code_ok, rd_fire, rd_good, rd_bad;

  // word bus wins over the byte bus in the same cycle
  assign push      = wr_en || bwr_en;
  assign push_data = wr_en ? wr_data : {bwr_data, 8'h00};

  vport_ring #(.DEPTH(RING_DEPTH), .DW(16)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .fill(fill)
  );

  vport_mems #(
    .ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW),
    .CRAM_WORDS(CRAM_WORDS), .SCROLL_WORDS(SCROLL_WORDS)
  ) u_mems (
    .clk(clk), .wr_en(wr_en), .wr_code(wr_code), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .vram_word(vram_word),
    .vram_byte(vram_byte), .cram_val(cram_val), .vs_val(vs_val)
  );

  always_comb begin
    code_ok = 1'b1;
    rd_mux  = '0;
    case (rd_code)
      RC_VRAM:  rd_mux = vram_word;
      RC_VSRAM: rd_mux = {fill[15:11], vs_val};
      RC_CRAM:  rd_mux = cram_expand(cram_val) | (fill & ~CRAM_BUS_MASK);
      RC_VBYTE: rd_mux = {fill[15:8], vram_byte};
      default:  code_ok = 1'b0;
    endcase
  end

  assign rd_ready = !locked;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_good  = rd_fire && code_ok;
  assign rd_bad   = rd_fire && !code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done     <= 1'b0;
      rd_data     <= '0;
      ctl_pending <= 1'b0;
      locked      <= 1'b0;
    end else begin
      rd_done <= rd_good;
      if (rd_good) rd_data <= rd_mux;
      if (rd_bad)  locked  <= 1'b1;
      if (rd_fire)       ctl_pending <= 1'b0;
      else if (ctl_half) ctl_pending <= 1'b1;
    end
  end

  // R8: a valid accepted read completes on the next cycle
  p_done_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_good |=> rd_done);
  // R8: no completion without an accepted valid read
  p_no_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_good |=> !rd_done);
  // R9: an accepted read leaves the pending flag clear
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !ctl_pending);
  // R10: an invalid read locks the port
  p_lock_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> locked);
  // R10: the lock is sticky
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: tb/vport_read_path_test.sv
`timescale 1ns/1ps
module vport_read_path_test;
  localparam int VBYTES = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, bwr_en = 0, ctl_half = 0, rd_valid = 0;
  logic [4:0] wr_code = 0, rd_code = 0;
  logic [15:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [7:0] bwr_data = 0;
  logic rd_ready, rd_done, ctl_pending, locked;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  vport_read_path uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code), .wr_addr(wr_addr),
    .wr_data(wr_data), .bwr_en(bwr_en), .bwr_data(bwr_data), .ctl_half(ctl_half),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_code(rd_code), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .ctl_pending(ctl_pending), .locked(locked)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  // reference model state
  int vram_m [VBYTES/2];
  int cram_m [64];
  int vs_m [40];
  int ring [4];
  int wp;
  bit m_lock, m_pend, e_done;
  int e_data, e_code;

  function automatic string req_of(input int c);
    case (c)
      0: return "R3";
      4: return "R4";
      8: return "R5";
      12: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic bit known(input int c);
    return (c == 0) || (c == 4) || (c == 8) || (c == 12);
  endfunction

  function automatic int model_read(input int c, input int a);
    int w, ofs, r, g, b, v;
    v = 0;
    if (c == 0) v = vram_m[(a % VBYTES) / 2];
    else if (c == 4) begin
      ofs = a % 128;
      v = (vs_m[(ofs >= 80) ? 0 : ofs / 2] % 2048) + (ring[wp] / 2048) * 2048;
    end else if (c == 8) begin
      w = cram_m[(a % 128) / 2];
      r = w % 8; g = (w / 8) % 8; b = (w / 64) % 8;
      v = b * 512 + g * 32 + r * 2;
      v = v | (ring[wp] & 'hF111);
    end else if (c == 12) begin
      w = vram_m[(a % VBYTES) / 2];
      v = ((a % 2) == 1) ? (w / 256) : (w % 256);
      v = v + (ring[wp] / 256) * 256;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_pend = 0; e_done = 0; wp = 0;
      for (int i = 0; i < 4; i++) ring[i] = 0;
      started = 1;
    end else begin
      e_done = 0;
      if (rd_valid && !m_lock) begin
        if (known(int'(rd_code))) begin
          e_done = 1; e_code = int'(rd_code);
          e_data = model_read(int'(rd_code), int'(rd_addr));
        end else m_lock = 1;
        m_pend = 0;
      end else if (ctl_half) m_pend = 1;
      if (wr_en) begin
        ring[wp] = int'(wr_data); wp = (wp + 1) % 4;
        if (wr_code == 5'h01) vram_m[(int'(wr_addr) % VBYTES) / 2] = int'(wr_data);
        if (wr_code == 5'h03)
          cram_m[(int'(wr_addr) % 128) / 2] = ((int'(wr_data) / 512) % 8) * 64 +
            ((int'(wr_data) / 32) % 8) * 8 + (int'(wr_data) / 2) % 8;
        if (wr_code == 5'h05 && (int'(wr_addr) % 128) < 80)
          vs_m[(int'(wr_addr) % 128) / 2] = int'(wr_data) % 2048;
      end else if (bwr_en) begin
        ring[wp] = int'(bwr_data) * 256; wp = (wp + 1) % 4;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rd_done !== e_done) begin
        errors++;
        $display("FAIL %s rd_done actual %0b expected %0b", e_done ? "R8" : "R10", rd_done, e_done);
      end
      if (e_done) begin
        checks++;
        if (int'(rd_data) != e_data || $isunknown(rd_data)) begin
          errors++;
          $display("FAIL %s rd_data code %0h actual %04h expected %04h", req_of(e_code), e_code, rd_data, e_data);
        end
      end
      checks++;
      if (ctl_pending !== m_pend) begin
        errors++;
        $display("FAIL R9 ctl_pending actual %0b expected %0b", ctl_pending, m_pend);
      end
      checks++;
      if (locked !== m_lock || rd_ready !== !m_lock) begin
        errors++;
        $display("FAIL R10 locked/ready actual %0b/%0b expected %0b/%0b", locked, rd_ready, m_lock, !m_lock);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <= 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] c, input logic [15:0] a, input logic [15:0] d);
    wr_en = 1; wr_code = c; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bw(input logic [7:0] d);
    bwr_en = 1; bwr_data = d;
    @(negedge clk);
    bwr_en = 0;
  endtask

  task automatic rd(input logic [4:0] c, input logic [15:0] a);
    rd_valid = 1; rd_code = c; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic hard_reset();
    @(negedge clk); #1 rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R7: fill the three memories
    wr(5'h01, 16'h0010, 16'hBEEF);
    wr(5'h01, 16'h0012, 16'h1234);
    wr(5'h01, 16'h07FE, 16'hC3A5);
    wr(5'h03, 16'h0000, 16'h0EEE);
    wr(5'h03, 16'h0006, 16'h0A42);
    wr(5'h03, 16'h007E, 16'h0246);
    wr(5'h05, 16'h0000, 16'hFABC);
    wr(5'h05, 16'h0002, 16'h0123);
    wr(5'h05, 16'h004E, 16'h07FF);
    wr(5'h05, 16'h0052, 16'h0555);   // dropped, offset beyond 0x50
    // R1: four distinct patterns through a ring-only code
    wr(5'h02, 16'h0000, 16'hA5F0);
    wr(5'h02, 16'h0000, 16'h5A0F);
    wr(5'h02, 16'h0000, 16'hF00F);
    wr(5'h02, 16'h0000, 16'h0FF0);
    rd(5'h08, 16'h0000);
    rd(5'h08, 16'h0006);
    rd(5'h04, 16'h0000);
    rd(5'h04, 16'h0002);
    rd(5'h04, 16'h004E);
    rd(5'h04, 16'h0050);   // folds to entry 0
    rd(5'h04, 16'h0052);
    rd(5'h00, 16'h0011);   // bit 0 ignored
    rd(5'h00, 16'h07FE);
    rd(5'h0C, 16'h0010);
    rd(5'h0C, 16'h0011);
    // R2: byte bus pushes move the fill source
    bw(8'h9C);
    rd(5'h08, 16'h007E);
    bw(8'h31);
    rd(5'h0C, 16'h0012);
    rd(5'h04, 16'h0002);
    // R2: both buses at once, word recorded
    wr_en = 1; wr_code = 5'h02; wr_data = 16'h7777; bwr_en = 1; bwr_data = 8'h11;
    @(negedge clk);
    wr_en = 0; bwr_en = 0;
    bw(8'hE4); bw(8'h00); bw(8'h00);
    rd(5'h08, 16'h0000);
    // R8: read and write in one cycle, read sees prior contents
    rd_valid = 1; rd_code = 5'h00; rd_addr = 16'h0010;
    wr_en = 1; wr_code = 5'h01; wr_addr = 16'h0010; wr_data = 16'h4321;
    @(negedge clk);
    rd_valid = 0; wr_en = 0;
    rd(5'h00, 16'h0010);
    // R9: pending set, held, then cleared by a read that collides with a set
    ctl_half = 1; @(negedge clk); ctl_half = 0;
    @(negedge clk);
    ctl_half = 1; rd_valid = 1; rd_code = 5'h0C; rd_addr = 16'h0013;
    @(negedge clk);
    ctl_half = 0; rd_valid = 0;
    @(negedge clk);
    // R10: invalid code locks, later reads refused, reset releases
    rd(5'h10, 16'h0000);
    rd(5'h00, 16'h0010);
    rd(5'h08, 16'h0000);
    repeat (3) @(negedge clk);
    hard_reset();
    rd(5'h00, 16'h0012);
    rd(5'h0C, 16'h0012);   // ring cleared by reset: upper byte 0
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule